// File: doc/BRIEF.md
# External Interrupt Controller with Per-Pin Trigger Selection

This block collects thirty-two asynchronous interrupt lines from outside the chip, arranged as four groups of eight. Every line passes through a two-flop synchronizer, and then a per-line trigger rule decides whether it raises a sticky pending flag. The trigger rule is one of five types: high level, low level, rising edge, falling edge, or either edge. Software reads the pending flags and clears them by writing ones. A per-line mask decides whether a pending flag reaches the interrupt outputs.

The sixteen lowest lines each drive their own registered request output. The sixteen upper lines are folded into a single shared request. That shared request comes with the number of the highest-numbered unmasked pending upper line and a valid flag, so a handler can pick a line without scanning. A small word-wide register port gives each group a trigger-type register, a mask register and a pending register.

Top module: `xirq_hub`

## Requirements
- R1: After reset, every trigger field holds 111 (detection off), so each trigger register reads 0x77777777. Every mask register reads 0xFF, every pending register reads 0x00, and all request outputs, `hi_idx_o` and `hi_vld_o` are 0.
- R2: The register address is {group[1:0], sel[1:0]}. sel 0 selects the trigger register, sel 1 the mask register and sel 2 the pending register. sel 3 reads zero and ignores writes. `reg_rdata` is registered and shows the register addressed at the previous rising edge.
- R3: In a trigger register, line k of the group uses bits 4k to 4k+2, and bit 4k+3 always reads 0. The encodings are 000 low level, 001 high level, 010 falling edge and 011 rising edge. Code 100 selects both edges. Codes 101 to 111 never set the pending flag.
- R4: Writing a 1 to pending bit k (k = line mod 8) clears it, and writing 0 leaves it unchanged. A pending flag never drops without such a write. If a clear and a new trigger fall in the same cycle, the trigger wins.
- R5: An edge type sets the pending flag once for each qualifying transition of the synchronized line. The flag stays set after the line returns to its previous level.
- R6: A level type sets the pending flag in every cycle that the synchronized line is at the active level. A clear written while the level is still active leaves the flag set.
- R7: A mask bit of 1 keeps the line's pending flag from every request output, and a mask bit of 0 lets it through. Pending flags latch regardless of the mask.
- R8: Line i (0 to 15) drives `irq_low_o[i]`. This output is high exactly when the line is pending and unmasked, and it follows the pending flag by one cycle.
- R9: `irq_hi_o` is high when any line from 16 to 31 is pending and unmasked. Upper lines never affect `irq_low_o`.
- R10: `hi_idx_o` gives the line number (16 to 31) of the highest-numbered unmasked pending upper line, and `hi_vld_o` flags it. Both outputs are 0 when no upper line qualifies.
- R11: Suppose a line changes between two clock edges and its type matches the change. Its request output then rises at the fourth rising edge after the change.

Ports are listed in the order of the port list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 32 | Asynchronous external interrupt lines |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address {group, sel} |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| irq_low_o | output | 16 | Individual requests of lines 0 to 15 |
| irq_hi_o | output | 1 | Shared request of lines 16 to 31 |
| hi_idx_o | output | 5 | Highest unmasked pending upper line number |
| hi_vld_o | output | 1 | `hi_idx_o` is meaningful |

## Verification
The pending flags are the only state that decides the outputs, so the bench reads them back through the register port. If a pending bit is wrong, it shows on the matching request output one cycle later. If a trigger field is wrong, the flag either fails to set or sets spuriously within three cycles of a line change. This is caught by comparing pending readback against the expected value after each stimulus. The cycle-exact latency test pins the synchronizer depth. Two further checks probe the priority encoder: two upper lines pending in the same group, and lines pending in different groups.

// File: rtl/xirq_pkg.sv
package xirq_pkg;

  localparam int FIELD_W     = 3;
  localparam int FIELD_PITCH = 4;

  localparam logic [1:0] SEL_TYPE = 2'd0;
  localparam logic [1:0] SEL_MASK = 2'd1;
  localparam logic [1:0] SEL_PEND = 2'd2;

  typedef enum logic [2:0] {
    TRIG_LVL_LO = 3'b000,
    TRIG_LVL_HI = 3'b001,
    TRIG_FALL   = 3'b010,
    TRIG_RISE   = 3'b011,
    TRIG_BOTH   = 3'b100,
    TRIG_OFF    = 3'b111
  } trig_e;

  function automatic logic trig_hit(input logic [2:0] kind,
                                    input logic       cur,
                                    input logic       prv);
    logic hit;
    case (kind)
      TRIG_LVL_LO: hit = !cur;
      TRIG_LVL_HI: hit = cur;
      TRIG_FALL:   hit = prv && !cur;
      TRIG_RISE:   hit = !prv && cur;
      TRIG_BOTH:   hit = prv ^ cur;
      default:     hit = 1'b0;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] lvl_o,
  output logic [WIDTH-1:0] prev_o
);

  localparam int DEPTH = STAGES + 1;

  logic [DEPTH-1:0][WIDTH-1:0] chain_q;

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= '0;
          else     chain_q[g] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= '0;
          else     chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign lvl_o  = chain_q[STAGES-1];
  assign prev_o = chain_q[STAGES];

endmodule

// File: rtl/xirq_bank.sv
module xirq_bank
  import xirq_pkg::*;
#(
  parameter int PINS = 8,
  localparam int RDW = FIELD_PITCH * PINS
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PINS-1:0] lvl_i,
  input  logic [PINS-1:0] prev_i,
  input  logic            we_type,
  input  logic            we_mask,
  input  logic            we_pend,
  input  logic [RDW-1:0]  wdata_i,
  output logic [RDW-1:0]  type_o,
  output logic [PINS-1:0] mask_o,
  output logic [PINS-1:0] pend_o
);

  logic [FIELD_W-1:0] trig_q [PINS];
  logic [PINS-1:0]    hit;
  logic [PINS-1:0]    clr;
  logic [PINS-1:0]    mask_q;
  logic [PINS-1:0]    pend_q;
  logic [PINS-1:0]    unused_pad;

  always_ff @(posedge clk) begin
    for (int k = 0; k < PINS; k++) begin
      if (rst)          trig_q[k] <= TRIG_OFF;
      else if (we_type) trig_q[k] <= wdata_i[FIELD_PITCH*k +: FIELD_W];
    end
  end

  genvar k;
  generate
    for (k = 0; k < PINS; k++) begin : g_pin
      assign hit[k] = trig_hit(trig_q[k], lvl_i[k], prev_i[k]);
      assign type_o[FIELD_PITCH*k +: FIELD_PITCH] = {1'b0, trig_q[k]};
      assign unused_pad[k] = wdata_i[FIELD_PITCH*k + FIELD_W];
    end
  endgenerate

  assign clr = we_pend ? wdata_i[PINS-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst)          mask_q <= '1;
    else if (we_mask) mask_q <= wdata_i[PINS-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= (pend_q & ~clr) | hit;
  end

  assign mask_o = mask_q;
  assign pend_o = pend_q;

  // R4: a one written clears the bit unless a trigger arrives in that cycle
  p_w1c_r4: assert property (@(posedge clk) disable iff (rst)
    we_pend |=> ((pend_q & $past(wdata_i[PINS-1:0] & ~hit)) == '0));

  // R4: a pending bit only drops through a clear write
  p_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    (($past(pend_q) & ~pend_q & ~$past(clr)) == '0));

  // R5 / R6: a detected trigger always leaves the bit set
  p_hit_sets_r6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend_q & $past(hit)) == $past(hit)));

endmodule

// File: rtl/xirq_prio.sv
module xirq_prio #(
  parameter int WIDTH = 16,
  localparam int IDX_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] vec_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);

  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = 0; i < WIDTH; i++) begin
      if (vec_i[i]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end

  // R10: the chosen index is set and nothing above it is set
  always_comb begin
    if (found_o) begin
      p_top_bit_r10: assert ((vec_i >> idx_o) == WIDTH'(1));
    end
  end

endmodule

// File: rtl/xirq_hub.sv
module xirq_hub
  import xirq_pkg::*;
#(
  parameter int NUM_BANKS   = 4,
  parameter int BANK_PINS   = 8,
  parameter int LOW_BANKS   = 2,
  parameter int SYNC_STAGES = 2,
  localparam int NPINS   = NUM_BANKS * BANK_PINS,
  localparam int LOW_PINS = LOW_BANKS * BANK_PINS,
  localparam int HI_PINS = NPINS - LOW_PINS,
  localparam int BANK_W  = $clog2(NUM_BANKS),
  localparam int ADDR_W  = BANK_W + 2,
  localparam int RDW     = FIELD_PITCH * BANK_PINS,
  localparam int IDX_W   = $clog2(NPINS),
  localparam int HIDX_W  = $clog2(HI_PINS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NPINS-1:0]    pin_i,
  input  logic                reg_we,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [RDW-1:0]      reg_wdata,
  output logic [RDW-1:0]      reg_rdata,
  output logic [LOW_PINS-1:0] irq_low_o,
  output logic                irq_hi_o,
  output logic [IDX_W-1:0]    hi_idx_o,
  output logic                hi_vld_o
);

  logic [NPINS-1:0] lvl;
  logic [NPINS-1:0] prev;

  xirq_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .async_i(pin_i),
    .lvl_o  (lvl),
    .prev_o (prev)
  );

  logic [BANK_W-1:0] sel_bank;
  logic [1:0]        sel_reg;

  assign sel_bank = reg_addr[ADDR_W-1:2];
  assign sel_reg  = reg_addr[1:0];

  logic [NUM_BANKS-1:0][RDW-1:0]       type_w;
  logic [NUM_BANKS-1:0][BANK_PINS-1:0] mask_w;
  logic [NUM_BANKS-1:0][BANK_PINS-1:0] pend_w;

  genvar b;
  generate
    for (b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic hit_bank;
      assign hit_bank = reg_we && (sel_bank == BANK_W'(b));

      xirq_bank #(.PINS(BANK_PINS)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .lvl_i  (lvl[b*BANK_PINS +: BANK_PINS]),
        .prev_i (prev[b*BANK_PINS +: BANK_PINS]),
        .we_type(hit_bank && (sel_reg == SEL_TYPE)),
        .we_mask(hit_bank && (sel_reg == SEL_MASK)),
        .we_pend(hit_bank && (sel_reg == SEL_PEND)),
        .wdata_i(reg_wdata),
        .type_o (type_w[b]),
        .mask_o (mask_w[b]),
        .pend_o (pend_w[b])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (sel_reg)
        SEL_TYPE: reg_rdata <= type_w[sel_bank];
        SEL_MASK: reg_rdata <= RDW'(mask_w[sel_bank]);
        SEL_PEND: reg_rdata <= RDW'(pend_w[sel_bank]);
        default:  reg_rdata <= '0;
      endcase
    end
  end

  logic [NPINS-1:0] mask_all;
  logic [NPINS-1:0] active;

  assign mask_all = mask_w;
  assign active   = pend_w & ~mask_all;

  logic              hi_found;
  logic [HIDX_W-1:0] hi_rel;

  xirq_prio #(.WIDTH(HI_PINS)) u_prio (
    .vec_i  (active[NPINS-1:LOW_PINS]),
    .found_o(hi_found),
    .idx_o  (hi_rel)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_low_o <= '0;
      irq_hi_o  <= 1'b0;
      hi_vld_o  <= 1'b0;
      hi_idx_o  <= '0;
    end else begin
      irq_low_o <= active[LOW_PINS-1:0];
      irq_hi_o  <= |active[NPINS-1:LOW_PINS];
      hi_vld_o  <= hi_found;
      hi_idx_o  <= hi_found ? (IDX_W'(LOW_PINS) + IDX_W'(hi_rel)) : '0;
    end
  end

  // R1: outputs come out of reset quiet
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (irq_low_o == '0 && !irq_hi_o && !hi_vld_o));

  // R7: a masked line never shows on its individual request
  p_mask_blocks_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((irq_low_o & $past(mask_all[LOW_PINS-1:0])) == '0));

  // R9: the shared request and the index valid flag agree
  p_hi_agree_r9: assert property (@(posedge clk) disable iff (rst)
    hi_vld_o == irq_hi_o);

  // R10: a reported index lies in the upper group, and is zero otherwise
  p_idx_range_r10: assert property (@(posedge clk) disable iff (rst)
    hi_vld_o ? (hi_idx_o >= IDX_W'(LOW_PINS)) : (hi_idx_o == '0));

endmodule

// File: tb/xirq_hub_bench.sv
module xirq_hub_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pins = '0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [15:0] irq_low_o;
  logic        irq_hi_o;
  logic [4:0]  hi_idx_o;
  logic        hi_vld_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  xirq_hub u_xirq_hub (
    .clk      (clk),
    .rst      (rst),
    .pin_i    (pins),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .irq_low_o(irq_low_o),
    .irq_hi_o (irq_hi_o),
    .hi_idx_o (hi_idx_o),
    .hi_vld_o (hi_vld_o)
  );

  task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", what, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; pins = '0; reg_we = 1'b0;
    tick(3);
    rst = 1'b0;
    tick(1);
  endtask

  function automatic logic [3:0] a_type(input int b); return 4'(b*4 + 0); endfunction
  function automatic logic [3:0] a_mask(input int b); return 4'(b*4 + 1); endfunction
  function automatic logic [3:0] a_pend(input int b); return 4'(b*4 + 2); endfunction

  task automatic t_reset();
    logic [31:0] v;
    do_reset();
    for (int b = 0; b < 4; b++) begin
      rd(a_type(b), v); chk("R1 type reset", v, 32'h77777777);
      rd(a_mask(b), v); chk("R1 mask reset", v, 32'h000000ff);
      rd(a_pend(b), v); chk("R1 pend reset", v, 32'h0);
    end
    chk("R1 outputs quiet", {irq_low_o, 8'd0, hi_idx_o, hi_vld_o, irq_hi_o}, 32'h0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    do_reset();
    wr(a_type(2), 32'hffffffff);
    rd(a_type(2), v); chk("R3 pad bits read zero", v, 32'h77777777);
    wr(a_mask(1), 32'h0000005a);
    rd(a_mask(1), v); chk("R2 mask readback", v, 32'h0000005a);
    wr(4'd3, 32'hffffffff);
    rd(4'd3, v); chk("R2 sel3 reads zero", v, 32'h0);
    rd(a_mask(0), v); chk("R2 sel3 write ignored", v, 32'h000000ff);
  endtask

  task automatic t_rising();
    logic [31:0] v;
    do_reset();
    wr(a_type(0), 32'h77773777);
    wr(a_mask(0), 32'h000000f7);
    pins[3] = 1'b1; tick(6);
    chk("R5 rise request", 32'(irq_low_o), 32'h0008);
    pins[3] = 1'b0; tick(6);
    rd(a_pend(0), v); chk("R5 rise sticky", v, 32'h08);
    wr(a_pend(0), 32'h00000008); tick(2);
    rd(a_pend(0), v); chk("R4 w1c clears", v, 32'h0);
    chk("R8 request drops", 32'(irq_low_o), 32'h0);
  endtask

  task automatic t_falling();
    logic [31:0] v;
    do_reset();
    wr(a_type(0), 32'h77277777);
    pins[5] = 1'b1; tick(6);
    rd(a_pend(0), v); chk("R5 fall ignores rise", v, 32'h0);
    pins[5] = 1'b0; tick(6);
    rd(a_pend(0), v); chk("R5 fall latches", v, 32'h20);
  endtask

  task automatic t_both();
    logic [31:0] v;
    do_reset();
    wr(a_type(1), 32'h77777747);
    pins[9] = 1'b1; tick(6);
    rd(a_pend(1), v); chk("R3 both on rise", v, 32'h02);
    wr(a_pend(1), 32'h000000fd); tick(2);
    rd(a_pend(1), v); chk("R4 zero bits unaffected", v, 32'h02);
    wr(a_pend(1), 32'h00000002); tick(2);
    pins[9] = 1'b0; tick(6);
    rd(a_pend(1), v); chk("R3 both on fall", v, 32'h02);
  endtask

  task automatic t_level();
    logic [31:0] v;
    do_reset();
    wr(a_type(1), 32'h77717777);
    wr(a_mask(1), 32'h000000ef);
    pins[12] = 1'b1; tick(6);
    chk("R6 level high request", 32'(irq_low_o), 32'h1000);
    wr(a_pend(1), 32'h00000010); tick(2);
    rd(a_pend(1), v); chk("R6 clear while active stays set", v, 32'h10);
    pins[12] = 1'b0; tick(5);
    wr(a_pend(1), 32'h00000010); tick(2);
    rd(a_pend(1), v); chk("R6 clear after release", v, 32'h0);
    wr(a_type(0), 32'h77777770); tick(3);
    rd(a_pend(0), v); chk("R6 level low on idle line", v, 32'h01);
  endtask

  task automatic t_mask();
    logic [31:0] v;
    do_reset();
    wr(a_type(0), 32'h77777377);
    pins[2] = 1'b1; tick(6);
    rd(a_pend(0), v); chk("R7 masked still latches", v, 32'h04);
    chk("R7 masked no request", 32'(irq_low_o), 32'h0);
    wr(a_mask(0), 32'h000000fb); tick(2);
    chk("R7 unmask raises request", 32'(irq_low_o), 32'h0004);
  endtask

  task automatic t_off_codes();
    logic [31:0] v;
    do_reset();
    wr(a_type(0), 32'h75677777);
    wr(a_mask(0), 32'h0);
    pins[5] = 1'b1; pins[6] = 1'b1; tick(6);
    pins[5] = 1'b0; pins[6] = 1'b0; tick(6);
    rd(a_pend(0), v); chk("R3 codes 5 and 6 never trigger", v, 32'h0);
    chk("R3 no request from off codes", 32'(irq_low_o), 32'h0);
  endtask

  task automatic t_upper();
    logic [31:0] v;
    do_reset();
    wr(a_type(2), 32'h77777737);
    wr(a_type(3), 32'h77377337);
    wr(a_mask(2), 32'h000000fd);
    wr(a_mask(3), 32'h000000dc);
    pins[17] = 1'b1; pins[29] = 1'b1; tick(6);
    chk("R9 shared request", 32'(irq_hi_o), 32'h1);
    chk("R10 highest across groups", {26'd0, hi_vld_o, hi_idx_o}, {26'd0, 1'b1, 5'd29});
    chk("R9 upper lines off low outputs", 32'(irq_low_o), 32'h0);
    wr(a_pend(3), 32'h00000020); tick(2);
    chk("R10 next after clear", {26'd0, hi_vld_o, hi_idx_o}, {26'd0, 1'b1, 5'd17});
    pins[24] = 1'b1; pins[25] = 1'b1; tick(6);
    chk("R10 highest within group", {26'd0, hi_vld_o, hi_idx_o}, {26'd0, 1'b1, 5'd25});
    wr(a_mask(3), 32'h000000ff);
    wr(a_mask(2), 32'h000000ff); tick(2);
    chk("R10 nothing valid", {26'd0, hi_vld_o, hi_idx_o}, 32'h0);
    chk("R9 shared request drops", 32'(irq_hi_o), 32'h0);
  endtask

  task automatic t_latency();
    do_reset();
    wr(a_type(0), 32'h77777737);
    wr(a_mask(0), 32'h000000fd);
    @(negedge clk);
    pins[1] = 1'b1;
    tick(3);
    chk("R11 low after three edges", 32'(irq_low_o), 32'h0);
    tick(1);
    chk("R11 high at fourth edge", 32'(irq_low_o), 32'h0002);
  endtask

  initial begin
    t_reset();
    t_regs();
    t_rising();
    t_falling();
    t_both();
    t_level();
    t_mask();
    t_off_codes();
    t_upper();
    t_latency();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

endmodule